// File: doc/BRIEF.md
# CEC Transmit Request Controller

This block keeps the three control bits that govern a CEC message transmission: the peripheral enable, the start-of-message request and the end-of-message marker. A register write port sets and clears them. The transmit engine reports how each attempt ended, and the block applies the matching set and clear rules. Software reads the start-of-message bit as a busy flag. It stays 1 from the request until the message finishes, fails or is aborted.

When a request is pending, the block watches two inputs: the receive-busy flag and the signal-free-time expiry. It issues a one-cycle launch strobe to the engine only when the line may be taken. At the same time it captures the initiator address from the upper nibble of the transmit byte, so the header carries that address. When arbitration is lost, the request stays pending and is launched again once the line becomes free. The end-of-message bit is passed to the engine as the EOM flag for the byte being sent. If that bit is set before the start request, the message is a single-byte ping.

Top module: `cec_txctl`

## Requirements
- R1: After reset, the register read value is 0, busy is 0, the launch strobe is 0 and the EOM flag is 0.
- R2: The register places enable at bit 0, start-of-message at bit 1 and end-of-message at bit 2, and bits above 2 read as zero. Enable is read/write. Writing 0 to bit 1 or bit 2 leaves those bits unchanged.
- R3: A write that sets bit 1 or bit 2 is ignored unless the stored enable bit is already 1.
- R4: While a transmission is active, any one of these events clears start-of-message and end-of-message at the same clock edge: done with acknowledge, underrun, negative acknowledge, or error.
- R5: A write with bit 0 equal to 0 clears start-of-message and end-of-message at that edge. It also ends any active transmission, and no launch follows.
- R6: Lost arbitration during an active transmission keeps start-of-message set and ends the attempt. A new launch follows once the launch conditions hold again.
- R7: The launch strobe lasts one cycle. It rises only when start-of-message is set, no reception is busy, signal-free time has expired and no transmission is active. A request made during reception therefore waits until the reception ends.
- R8: If end-of-message is set before start-of-message, the launch happens with the EOM flag at 1 (a ping).
- R9: At each launch, the initiator output holds bits 7:4 of the transmit byte that was present at the launch edge.
- R10: Outcome events that arrive while no transmission is active have no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DW | Register write value |
| rd_data | output | DW | Register read value |
| tx_byte | input | 8 | Current transmit data byte |
| ev_done | input | 1 | Last byte sent with acknowledge |
| ev_underrun | input | 1 | Transmit underrun |
| ev_nack | input | 1 | Negative acknowledge |
| ev_error | input | 1 | Transmit error |
| ev_arb_lost | input | 1 | Arbitration lost |
| rx_busy | input | 1 | Reception in progress |
| sft_expired | input | 1 | Signal-free time has elapsed |
| busy | output | 1 | Request pending or executing |
| launch | output | 1 | One-cycle start-bit launch strobe |
| cur_eom | output | 1 | EOM flag for the current byte |
| initiator | output | 4 | Initiator address captured at launch |

## Verification
The bench builds the block with the default 32-bit register width. This confirms that the reserved upper bits read as zero across the full word. The launch strobe is compared against a queue of expected launches, each holding its initiator and EOM value, so an extra launch or a missing one is reported. The stimulus holds off reception and signal-free time to exercise deferral and retry after lost arbitration. It also sends outcome events while no transmission is active and aborts by disable while a request is still pending.

// File: rtl/cec_txctl_pkg.sv
package cec_txctl_pkg;
  localparam int BIT_EN  = 0;
  localparam int BIT_SOM = 1;
  localparam int BIT_EOM = 2;
  localparam int BYTE_W  = 8;
  localparam int INIT_W  = 4;

  typedef struct packed {
    logic eom;
    logic som;
    logic en;
  } ctl_bits_t;

  typedef struct packed {
    logic done;
    logic underrun;
    logic nack;
    logic error;
    logic arb_lost;
  } tx_evt_t;
endpackage

// File: rtl/cec_txctl_evt.sv
module cec_txctl_evt
  import cec_txctl_pkg::*;
(
  input  tx_evt_t evt,
  input  logic    act,
  output logic    stop,
  output logic    retry
);
  logic terminal;

  always_comb begin
    terminal = evt.done | evt.underrun | evt.nack | evt.error;
    stop     = act & terminal;
    retry    = act & evt.arb_lost & ~terminal;
  end
endmodule

// File: rtl/cec_txctl_regs.sv
module cec_txctl_regs
  import cec_txctl_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          stop,
  output ctl_bits_t     q,
  output ctl_bits_t     nxt
);
  logic set_som;
  logic set_eom;

  always_comb begin
    set_som = wr_en & q.en & wr_data[BIT_SOM];
    set_eom = wr_en & q.en & wr_data[BIT_EOM];
    nxt.en  = wr_en ? wr_data[BIT_EN] : q.en;
    if (!nxt.en || stop) begin
      nxt.som = 1'b0;
      nxt.eom = 1'b0;
    end else begin
      nxt.som = q.som | set_som;
      nxt.eom = q.eom | set_eom;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/cec_txctl_launch.sv
module cec_txctl_launch
  import cec_txctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctl_bits_t         q,
  input  ctl_bits_t         nxt,
  input  logic              retry,
  input  logic              rx_busy,
  input  logic              sft_expired,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              act,
  output logic              launch,
  output logic [INIT_W-1:0] initiator
);
  logic go;
  logic act_nxt;

  always_comb begin
    go = q.en & q.som & nxt.som & ~rx_busy & sft_expired & ~act;
    if (!nxt.som || retry) act_nxt = 1'b0;
    else if (go)           act_nxt = 1'b1;
    else                   act_nxt = act;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act       <= 1'b0;
      launch    <= 1'b0;
      initiator <= '0;
    end else begin
      act    <= act_nxt;
      launch <= go;
      if (go) initiator <= tx_byte[BYTE_W-1 -: INIT_W];
    end
  end
endmodule

// File: rtl/cec_txctl.sv
module cec_txctl
  import cec_txctl_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              ev_done,
  input  logic              ev_underrun,
  input  logic              ev_nack,
  input  logic              ev_error,
  input  logic              ev_arb_lost,
  input  logic              rx_busy,
  input  logic              sft_expired,
  output logic              busy,
  output logic              launch,
  output logic              cur_eom,
  output logic [INIT_W-1:0] initiator
);
  ctl_bits_t ctl_q;
  ctl_bits_t ctl_nxt;
  tx_evt_t   evt;
  logic      tx_act;
  logic      stop;
  logic      retry;

  assign evt = '{done: ev_done, underrun: ev_underrun, nack: ev_nack,
                 error: ev_error, arb_lost: ev_arb_lost};

  cec_txctl_evt u_evt (
    .evt   (evt),
    .act   (tx_act),
    .stop  (stop),
    .retry (retry)
  );

  cec_txctl_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .stop    (stop),
    .q       (ctl_q),
    .nxt     (ctl_nxt)
  );

  cec_txctl_launch u_launch (
    .clk         (clk),
    .rst         (rst),
    .q           (ctl_q),
    .nxt         (ctl_nxt),
    .retry       (retry),
    .rx_busy     (rx_busy),
    .sft_expired (sft_expired),
    .tx_byte     (tx_byte),
    .act         (tx_act),
    .launch      (launch),
    .initiator   (initiator)
  );

  always_comb begin
    rd_data          = '0;
    rd_data[BIT_EN]  = ctl_q.en;
    rd_data[BIT_SOM] = ctl_q.som;
    rd_data[BIT_EOM] = ctl_q.eom;
  end

  assign busy    = ctl_q.som;
  assign cur_eom = ctl_q.eom;
endmodule

// File: rtl/cec_txctl_chk.sv
module cec_txctl_chk
  import cec_txctl_pkg::*;
#(
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DW-1:0]     wr_data,
  input logic [DW-1:0]     rd_data,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              ev_done,
  input logic              ev_underrun,
  input logic              ev_nack,
  input logic              ev_error,
  input logic              ev_arb_lost,
  input logic              rx_busy,
  input logic              sft_expired,
  input logic              busy,
  input logic              launch,
  input logic              cur_eom,
  input logic [INIT_W-1:0] initiator,
  input logic              act
);
  logic terminal;
  logic dis_wr;
  assign terminal = ev_done | ev_underrun | ev_nack | ev_error;
  assign dis_wr   = wr_en & ~wr_data[BIT_EN];

  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (!rd_data[BIT_EN] && !busy && wr_en && wr_data[BIT_SOM]) |=> !busy); // R3
  AST_OUTCOME_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (act && terminal) |=> (!busy && !cur_eom)); // R4
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    dis_wr |=> (!busy && !cur_eom && !launch)); // R5
  AST_ARB_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (act && ev_arb_lost && !terminal && !dis_wr) |=> busy); // R6
  AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (rst)
    launch |=> !launch); // R7
  AST_LAUNCH_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(launch) |-> ($past(!rx_busy && sft_expired) && busy)); // R7
  AST_EOM_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !cur_eom); // R4
  AST_INIT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    launch |-> (initiator == $past(tx_byte[BYTE_W-1 -: INIT_W]))); // R9
  AST_IDLE_EVT: assert property (@(posedge clk) disable iff (rst)
    (!act && busy && !dis_wr) |=> busy); // R10
endmodule

bind cec_txctl cec_txctl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .tx_byte(tx_byte), .ev_done(ev_done), .ev_underrun(ev_underrun),
  .ev_nack(ev_nack), .ev_error(ev_error), .ev_arb_lost(ev_arb_lost),
  .rx_busy(rx_busy), .sft_expired(sft_expired), .busy(busy), .launch(launch),
  .cur_eom(cur_eom), .initiator(initiator), .act(tx_act)
);

// File: tb/cec_txctl_tb.sv
module cec_txctl_tb;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [7:0]    tx_byte = 8'h00;
  logic          ev_done = 1'b0, ev_underrun = 1'b0, ev_nack = 1'b0;
  logic          ev_error = 1'b0, ev_arb_lost = 1'b0;
  logic          rx_busy = 1'b0, sft_expired = 1'b1;
  logic          busy, launch, cur_eom;
  logic [3:0]    initiator;

  int total = 0;
  int bad   = 0;
  logic [4:0] expq[$];  // {eom, initiator}

  always #2 clk = ~clk;

  cec_txctl #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tx_byte(tx_byte), .ev_done(ev_done), .ev_underrun(ev_underrun),
    .ev_nack(ev_nack), .ev_error(ev_error), .ev_arb_lost(ev_arb_lost),
    .rx_busy(rx_busy), .sft_expired(sft_expired), .busy(busy), .launch(launch),
    .cur_eom(cur_eom), .initiator(initiator)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(logic [DW-1:0] v);
    wr_en = 1'b1; wr_data = v;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic expect_launch(logic eom, logic [3:0] init);
    expq.push_back({eom, init});
  endtask

  // monitor: compare each launch against the scoreboard (R7, R8, R9)
  always @(negedge clk) begin
    if (!rst && launch) begin
      if (expq.size() == 0) begin
        check("R7 unexpected launch", 1, 0);
      end else begin
        logic [4:0] e;
        e = expq.pop_front();
        check("R8 eom at launch", cur_eom, e[4]);
        check("R9 initiator", initiator, e[3:0]);
      end
    end
  end

  initial begin
    #400000;
    check("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    check("R1 rd", rd_data, 0);
    check("R1 busy", busy, 0);
    check("R1 launch", launch, 0);
    check("R1 eom", cur_eom, 0);

    // R3: set attempts while disabled
    wr(32'h2);  check("R3 som ignored", rd_data, 0);
    wr(32'h6);  check("R3 eom ignored", rd_data, 0);

    // R2: enable, upper bits zero
    wr(32'hFFFF_FFF9); check("R2 enable only", rd_data, 32'h1);

    // normal message, eom added during transmission
    tx_byte = 8'h4A;
    expect_launch(1'b0, 4'h4);
    wr(32'h3); check("R2 som set", rd_data, 32'h3);
    tick(3);
    check("R7 single launch drained", expq.size(), 0);
    wr(32'h5); check("R2 eom set, som kept", rd_data, 32'h7);
    ev_nack = 1'b1; tick(); ev_nack = 1'b0;
    check("R4 nack clears", rd_data, 32'h1);

    // deferral behind reception
    rx_busy = 1'b1; tx_byte = 8'hB3;
    wr(32'h3);
    tick(4);
    check("R7 deferred busy", busy, 1);
    // R10: outcome while not active is ignored
    ev_done = 1'b1; tick(); ev_done = 1'b0;
    check("R10 idle event ignored", rd_data, 32'h3);
    // R2: writing 0 to som has no effect
    wr(32'h1); check("R2 zero write keeps som", rd_data, 32'h3);
    expect_launch(1'b0, 4'hB);
    rx_busy = 1'b0;
    tick(3);
    check("R7 launch after rx", expq.size(), 0);
    ev_done = 1'b1; tick(); ev_done = 1'b0;
    check("R4 done clears", rd_data, 32'h1);

    // arbitration lost with retry
    sft_expired = 1'b0; tx_byte = 8'h2C;
    wr(32'h3); tick(3);
    check("R7 waits for sft", expq.size(), 0);
    expect_launch(1'b0, 4'h2);
    sft_expired = 1'b1; tick(2);
    sft_expired = 1'b0;
    ev_arb_lost = 1'b1; tick(); ev_arb_lost = 1'b0;
    check("R6 som kept", rd_data, 32'h3);
    tick(3);
    tx_byte = 8'h9C;
    expect_launch(1'b0, 4'h9);
    sft_expired = 1'b1; tick(3);
    check("R6 relaunch", expq.size(), 0);
    ev_error = 1'b1; tick(); ev_error = 1'b0;
    check("R4 error clears", rd_data, 32'h1);

    // ping
    tx_byte = 8'h7F;
    wr(32'h5); tick(2);
    check("R8 eom without som", rd_data, 32'h5);
    expect_launch(1'b1, 4'h7);
    wr(32'h7); tick(3);
    check("R8 ping launched", expq.size(), 0);
    ev_underrun = 1'b1; tick(); ev_underrun = 1'b0;
    check("R4 underrun clears", rd_data, 32'h1);
    check("R4 eom cleared", cur_eom, 0);

    // disable aborts a pending request
    rx_busy = 1'b1;
    wr(32'h7); check("R5 pending", rd_data, 32'h7);
    wr(32'h0); check("R5 disable clears", rd_data, 0);
    rx_busy = 1'b0; tick(4);
    check("R5 no launch after abort", busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule